// File: doc/BRIEF.md
# Almost-Empty / Almost-Full Threshold Programmer

This block holds the two thresholds that a FIFO uses for its early-warning flags. It also produces those flags. One register, X, sets how close to empty the FIFO may get before the almost-empty flag goes active. A second register, Y, sets how close to full the FIFO may get before the almost-full flag goes active.

The three flag-select pins choose how the thresholds get their values. Their level on the last clock of the main reset fixes the method until the next main reset. There are three methods:

- A preset loads both registers with a fixed value during reset.
- A parallel load takes the low bits of the write data bus on a strobe.
- A serial load shifts one bit per clock from a select pin, which then serves as serial data. A second select pin serves as serial enable.

The FIFO occupancy count drives the two flags through registered comparators. A partial reset drives both flags to their idle levels. It keeps the thresholds, the chosen method and any load progress.

Top module: `almost_flag_offset_unit`

## Requirements
- R1: While `rst` is high, every clock edge sets `ae_n` to 0 and `af_n` to 1.
- R2: The value of `{fs2, fs1_sen, fs0_sdata}` on the last clock edge with `rst` high sets the load method. Code 3'b000 selects serial and 3'b001 selects parallel. Any other code selects a preset.
- R3: A reset with a preset code loads both X and Y with the preset value: 3'b010→8, 3'b011→16, 3'b100→64, 3'b101→256, 3'b110→1024, 3'b111→1024. A reset with code 3'b000 or 3'b001 clears X and Y to 0. In preset method, neither the strobe nor serial enable changes X or Y.
- R4: In parallel method, the first `ld_strobe` clock loads X from `wr_data[OFS_W-1:0]` and the second loads Y. Each new value is visible on the next clock.
- R5: In parallel method, strobes after the second one do not change X or Y. In serial method, `ld_strobe` has no effect.
- R6: In serial method, each clock with `fs1_sen` high shifts `fs0_sdata` into the LSB of the register being filled, so bits arrive MSB first. The first OFS_W bits fill X and the next OFS_W bits fill Y. Clocks with `fs1_sen` low shift nothing.
- R7: In serial method, bits after the first 2·OFS_W enabled bits do not change X or Y. In parallel method, `fs1_sen` has no effect.
- R8: Outside reset and partial reset, `ae_n` becomes 0 one clock after `occupancy` ≤ X and 1 otherwise.
- R9: Outside reset and partial reset, `af_n` becomes 0 one clock after DEPTH − `occupancy` ≤ Y and 1 otherwise.
- R10: While `prst` is high, `ae_n` goes to 0 and `af_n` to 1. X, Y, the method and load progress are all kept, and no load takes place.
- R11: After reset, a change on the select pins does not change the method. The pins then matter only as serial data and enable.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Main synchronous reset, active high |
| prst | input | 1 | Partial reset, active high |
| fs0_sdata | input | 1 | Select bit 0; serial data after reset |
| fs1_sen | input | 1 | Select bit 1; serial enable after reset |
| fs2 | input | 1 | Select bit 2 |
| wr_data | input | DATA_W | Write data bus, source of parallel loads |
| ld_strobe | input | 1 | Parallel load strobe |
| occupancy | input | CNT_W | Words held in the FIFO (0..DEPTH) |
| x_ofs | output | OFS_W | Almost-empty threshold X |
| y_ofs | output | OFS_W | Almost-full threshold Y |
| ae_n | output | 1 | Almost-empty flag, active low |
| af_n | output | 1 | Almost-full flag, active low |

## Verification
On every cycle, the assertions check:

- the idle flag levels during both kinds of reset;
- the one-cycle flag comparison against the thresholds;
- that the thresholds hold still whenever the chosen method gives them no load event;
- that the method stays put after reset.

Only the bench scenarios can show the rest:

- that the right preset value goes with each code;
- that the method is captured on the last reset clock;
- the X-then-Y order with MSB-first serial shifting;
- that loads are ignored once programming is complete;
- that a partial reset in the middle of a serial load keeps its progress.

// File: rtl/aoff_pkg.sv
package aoff_pkg;

  typedef enum logic [1:0] {
    LM_SERIAL   = 2'd0,
    LM_PARALLEL = 2'd1,
    LM_PRESET   = 2'd2
  } load_mode_e;

  function automatic load_mode_e mode_of(input logic [2:0] code);
    case (code)
      3'b000:  return LM_SERIAL;
      3'b001:  return LM_PARALLEL;
      default: return LM_PRESET;
    endcase
  endfunction

  function automatic int unsigned preset_of(input logic [2:0] code);
    case (code)
      3'b010:  return 8;
      3'b011:  return 16;
      3'b100:  return 64;
      3'b101:  return 256;
      3'b110,
      3'b111:  return 1024;
      default: return 0;
    endcase
  endfunction

endpackage

// File: rtl/ofs_mode_latch.sv
module ofs_mode_latch
  import aoff_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic [2:0] fsel,
  output load_mode_e mode
);

  // Tracks the pins for as long as reset is held; the last value stays.
  always_ff @(posedge clk) begin
    if (rst) mode <= mode_of(fsel);
  end

endmodule

// File: rtl/ofs_load_engine.sv
module ofs_load_engine
  import aoff_pkg::*;
#(
  parameter int OFS_W  = 11,
  parameter int DATA_W = 36
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              prst,
  input  load_mode_e        mode,
  input  logic [2:0]        fsel,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              ld_strobe,
  output logic [OFS_W-1:0]  x_ofs,
  output logic [OFS_W-1:0]  y_ofs
);

  localparam int SCNT_W = $clog2(2*OFS_W + 1);
  localparam logic [SCNT_W-1:0] BITS_TOTAL = SCNT_W'(2*OFS_W);
  localparam logic [SCNT_W-1:0] BITS_X     = SCNT_W'(OFS_W);

  typedef enum logic [1:0] {PS_WANT_X, PS_WANT_Y, PS_DONE} pstage_e;

  logic [SCNT_W-1:0] scnt;
  pstage_e           pstage;
  logic [OFS_W-1:0]  rst_val;
  logic              sd, sen;
  logic              ser_go, par_go;

  assign sd      = fsel[0];
  assign sen     = fsel[1];
  assign rst_val = OFS_W'(preset_of(fsel));
  assign ser_go  = !prst && (mode == LM_SERIAL) && sen && (scnt != BITS_TOTAL);
  assign par_go  = !prst && (mode == LM_PARALLEL) && ld_strobe && (pstage != PS_DONE);

  always_ff @(posedge clk) begin
    if (rst) begin
      x_ofs  <= rst_val;
      y_ofs  <= rst_val;
      scnt   <= '0;
      pstage <= PS_WANT_X;
    end else begin
      if (ser_go) begin
        if (scnt < BITS_X) x_ofs <= {x_ofs[OFS_W-2:0], sd};
        else               y_ofs <= {y_ofs[OFS_W-2:0], sd};
        scnt <= scnt + 1'b1;
      end
      if (par_go) begin
        if (pstage == PS_WANT_X) begin
          x_ofs  <= wr_data[OFS_W-1:0];
          pstage <= PS_WANT_Y;
        end else begin
          y_ofs  <= wr_data[OFS_W-1:0];
          pstage <= PS_DONE;
        end
      end
    end
  end

endmodule

// File: rtl/ofs_flag_cmp.sv
module ofs_flag_cmp #(
  parameter int   CNT_W    = 12,
  parameter int   OFS_W    = 11,
  parameter logic IDLE_VAL = 1'b0
) (
  input  logic             clk,
  input  logic             force_idle,
  input  logic [CNT_W-1:0] level,
  input  logic [OFS_W-1:0] limit,
  output logic             flag_n
);

  logic [CNT_W-1:0] limit_ext;
  assign limit_ext = CNT_W'(limit);

  always_ff @(posedge clk) begin
    if (force_idle) flag_n <= IDLE_VAL;
    else            flag_n <= (level > limit_ext);
  end

endmodule

// File: rtl/almost_flag_offset_unit.sv
module almost_flag_offset_unit
  import aoff_pkg::*;
#(
  parameter  int DEPTH  = 2048,
  parameter  int DATA_W = 36,
  localparam int OFS_W  = $clog2(DEPTH),
  localparam int CNT_W  = $clog2(DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              prst,
  input  logic              fs0_sdata,
  input  logic              fs1_sen,
  input  logic              fs2,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              ld_strobe,
  input  logic [CNT_W-1:0]  occupancy,
  output logic [OFS_W-1:0]  x_ofs,
  output logic [OFS_W-1:0]  y_ofs,
  output logic              ae_n,
  output logic              af_n
);

  logic [2:0]       fsel;
  load_mode_e       mode_w;
  logic [CNT_W-1:0] free_w;
  logic             idle_w;

  assign fsel   = {fs2, fs1_sen, fs0_sdata};
  assign free_w = CNT_W'(DEPTH) - occupancy;
  assign idle_w = rst | prst;

  ofs_mode_latch u_mode (
    .clk  (clk),
    .rst  (rst),
    .fsel (fsel),
    .mode (mode_w)
  );

  ofs_load_engine #(.OFS_W(OFS_W), .DATA_W(DATA_W)) u_load (
    .clk       (clk),
    .rst       (rst),
    .prst      (prst),
    .mode      (mode_w),
    .fsel      (fsel),
    .wr_data   (wr_data),
    .ld_strobe (ld_strobe),
    .x_ofs     (x_ofs),
    .y_ofs     (y_ofs)
  );

  ofs_flag_cmp #(.CNT_W(CNT_W), .OFS_W(OFS_W), .IDLE_VAL(1'b0)) u_ae (
    .clk        (clk),
    .force_idle (idle_w),
    .level      (occupancy),
    .limit      (x_ofs),
    .flag_n     (ae_n)
  );

  ofs_flag_cmp #(.CNT_W(CNT_W), .OFS_W(OFS_W), .IDLE_VAL(1'b1)) u_af (
    .clk        (clk),
    .force_idle (idle_w),
    .level      (free_w),
    .limit      (y_ofs),
    .flag_n     (af_n)
  );

endmodule

// File: rtl/almost_flag_offset_chk.sv
module almost_flag_offset_chk
  import aoff_pkg::*;
#(
  parameter int DEPTH = 2048,
  parameter int OFS_W = 11,
  parameter int CNT_W = 12
) (
  input logic             clk,
  input logic             rst,
  input logic             prst,
  input load_mode_e       mode,
  input logic             ld_strobe,
  input logic             sen,
  input logic [CNT_W-1:0] occupancy,
  input logic [OFS_W-1:0] x_ofs,
  input logic [OFS_W-1:0] y_ofs,
  input logic             ae_n,
  input logic             af_n
);

  // R1: idle flag levels follow a clock with reset high
  p_reset_flags_r1: assert property (@(posedge clk)
    rst |=> (!ae_n && af_n));

  // R11: method fixed once reset has been released
  p_mode_hold_r11: assert property (@(posedge clk) disable iff (rst)
    !$past(rst) |-> $stable(mode));

  // R3: preset method never moves the thresholds
  p_preset_hold_r3: assert property (@(posedge clk) disable iff (rst)
    (mode == LM_PRESET) |=> ($stable(x_ofs) && $stable(y_ofs)));

  // R5: parallel method moves thresholds only on a strobe
  p_par_idle_r5: assert property (@(posedge clk) disable iff (rst)
    (mode == LM_PARALLEL && !ld_strobe) |=> ($stable(x_ofs) && $stable(y_ofs)));

  // R7: serial method moves thresholds only with enable high
  p_ser_idle_r7: assert property (@(posedge clk) disable iff (rst)
    (mode == LM_SERIAL && !sen) |=> ($stable(x_ofs) && $stable(y_ofs)));

  // R10: partial reset keeps thresholds and idles the flags
  p_partial_hold_r10: assert property (@(posedge clk) disable iff (rst)
    prst |=> ($stable(x_ofs) && $stable(y_ofs) && !ae_n && af_n));

  // R8: almost-empty follows occupancy against X one clock later
  p_ae_cmp_r8: assert property (@(posedge clk) disable iff (rst)
    !prst |=> (ae_n == ($past(occupancy) > CNT_W'($past(x_ofs)))));

  // R9: almost-full follows free space against Y one clock later
  p_af_cmp_r9: assert property (@(posedge clk) disable iff (rst)
    !prst |=> (af_n == ((CNT_W'(DEPTH) - $past(occupancy)) > CNT_W'($past(y_ofs)))));

endmodule

bind almost_flag_offset_unit almost_flag_offset_chk #(
  .DEPTH(DEPTH), .OFS_W(OFS_W), .CNT_W(CNT_W)
) u_chk (
  .clk       (clk),
  .rst       (rst),
  .prst      (prst),
  .mode      (mode_w),
  .ld_strobe (ld_strobe),
  .sen       (fs1_sen),
  .occupancy (occupancy),
  .x_ofs     (x_ofs),
  .y_ofs     (y_ofs),
  .ae_n      (ae_n),
  .af_n      (af_n)
);

// File: tb/tb_almost_flag_offset_unit.sv
`timescale 1ns/1ps
module tb_almost_flag_offset_unit;

  localparam int DEPTH  = 2048;
  localparam int DATA_W = 36;
  localparam int OFS_W  = 11;
  localparam int CNT_W  = 12;
  localparam int OMASK  = (1 << OFS_W) - 1;

  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic              rst, prst, ld_strobe;
  logic [2:0]        fsel;
  logic [DATA_W-1:0] wr_data;
  logic [CNT_W-1:0]  occ;
  logic [OFS_W-1:0]  x_ofs, y_ofs;
  logic              ae_n, af_n;

  almost_flag_offset_unit #(.DEPTH(DEPTH), .DATA_W(DATA_W)) dut (
    .clk(clk), .rst(rst), .prst(prst),
    .fs0_sdata(fsel[0]), .fs1_sen(fsel[1]), .fs2(fsel[2]),
    .wr_data(wr_data), .ld_strobe(ld_strobe), .occupancy(occ),
    .x_ofs(x_ofs), .y_ofs(y_ofs), .ae_n(ae_n), .af_n(af_n)
  );

  int compared = 0;
  int mismatched = 0;
  string cur_req = "R1";
  bit done = 0;
  int ptab [8] = '{0, 0, 8, 16, 64, 256, 1024, 1024};

  // behavioural reference
  int m_mode, m_x, m_y, m_pst, m_scnt;
  bit m_ae, m_af, m_valid = 0;

  always @(posedge clk) begin
    if (rst) begin
      m_mode = (fsel == 3'd0) ? 0 : (fsel == 3'd1) ? 1 : 2;
      m_x = ptab[fsel]; m_y = ptab[fsel];
      m_pst = 0; m_scnt = 0; m_ae = 0; m_af = 1; m_valid = 1;
    end else if (prst) begin
      m_ae = 0; m_af = 1;
    end else begin
      m_ae = (int'(occ) > m_x);
      m_af = ((DEPTH - int'(occ)) > m_y);
      if (m_mode == 1 && ld_strobe && m_pst < 2) begin
        if (m_pst == 0) m_x = int'(wr_data) & OMASK;
        else            m_y = int'(wr_data) & OMASK;
        m_pst++;
      end else if (m_mode == 0 && fsel[1] && m_scnt < 2*OFS_W) begin
        if (m_scnt < OFS_W) m_x = ((m_x << 1) | int'(fsel[0])) & OMASK;
        else                m_y = ((m_y << 1) | int'(fsel[0])) & OMASK;
        m_scnt++;
      end
    end
  end

  always @(negedge clk) begin
    if (m_valid && !done) begin
      compared++;
      if (int'(x_ofs) != m_x || int'(y_ofs) != m_y || ae_n != m_ae || af_n != m_af) begin
        mismatched++;
        $display("FAIL %s model: x=%0d/%0d y=%0d/%0d ae_n=%0b/%0b af_n=%0b/%0b (act/exp)",
                 cur_req, x_ofs, m_x, y_ofs, m_y, ae_n, m_ae, af_n, m_af);
      end
    end
  end

  task automatic chk(input string req, input string what, input int act, input int exp);
    compared++;
    if (act != exp) begin
      mismatched++;
      $display("FAIL %s %s act=%0d exp=%0d", req, what, act, exp);
    end
  endtask

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic shift_word(input int val, input int gap_every);
    for (int i = OFS_W - 1; i >= 0; i--) begin
      fsel = {1'b0, 1'b1, 1'((val >> i) & 1)};
      tick(1);
      if (gap_every > 0 && (i % gap_every) == 0) begin
        fsel = {1'b1, 1'b0, ~1'((val >> i) & 1)};
        tick(1);
      end
    end
    fsel = 3'b000;
  endtask

  initial begin
    rst = 1; prst = 0; fsel = 3'b100; ld_strobe = 0; wr_data = '0; occ = '0;
    tick(3);
    cur_req = "R1";
    chk("R1", "ae_n in reset", int'(ae_n), 0);
    chk("R1", "af_n in reset", int'(af_n), 1);

    // preset 64, then pins move (R11)
    rst = 0; fsel = 3'b011; tick(1);
    cur_req = "R3";
    chk("R3", "x preset 64", int'(x_ofs), 64);
    chk("R3", "y preset 64", int'(y_ofs), 64);
    fsel = 3'b000;
    ld_strobe = 1; wr_data = 36'd5; tick(2); ld_strobe = 0;
    chk("R3", "x after strobe in preset", int'(x_ofs), 64);
    fsel = 3'b010; tick(3); fsel = 3'b000;
    chk("R11", "x after sen in preset", int'(x_ofs), 64);

    cur_req = "R8";
    occ = 64; tick(1); chk("R8", "ae_n occ=X", int'(ae_n), 0);
    occ = 65; tick(1); chk("R8", "ae_n occ=X+1", int'(ae_n), 1);
    occ = 0;  tick(1); chk("R8", "ae_n occ=0", int'(ae_n), 0);
    cur_req = "R9";
    occ = 1984; tick(1); chk("R9", "af_n free=Y", int'(af_n), 0);
    occ = 1983; tick(1); chk("R9", "af_n free=Y+1", int'(af_n), 1);
    occ = 2048; tick(1); chk("R9", "af_n full", int'(af_n), 0);
    chk("R8", "ae_n full", int'(ae_n), 1);

    cur_req = "R10";
    prst = 1; occ = 1000; tick(2);
    chk("R10", "ae_n in prst", int'(ae_n), 0);
    chk("R10", "af_n in prst", int'(af_n), 1);
    chk("R10", "x kept in prst", int'(x_ofs), 64);
    prst = 0; tick(1);
    chk("R10", "ae_n after prst", int'(ae_n), 1);
    chk("R10", "mode kept (x)", int'(y_ofs), 64);

    // every preset code
    cur_req = "R3";
    for (int c = 2; c < 8; c++) begin
      rst = 1; fsel = 3'(c); tick(2);
      rst = 0; fsel = 3'b000; tick(1);
      chk("R3", $sformatf("x preset code %0d", c), int'(x_ofs), ptab[c]);
      chk("R3", $sformatf("y preset code %0d", c), int'(y_ofs), ptab[c]);
    end

    // parallel: last reset clock decides (R2)
    cur_req = "R2";
    rst = 1; fsel = 3'b000; tick(1); fsel = 3'b001; tick(1);
    rst = 0; fsel = 3'b110; tick(2);
    chk("R3", "x cleared in parallel", int'(x_ofs), 0);
    chk("R7", "sen ignored in parallel", int'(y_ofs), 0);
    cur_req = "R4";
    wr_data = 36'hF_0000_0805; ld_strobe = 1; tick(1); ld_strobe = 0;
    chk("R4", "x first strobe", int'(x_ofs), 5);
    chk("R4", "y untouched", int'(y_ofs), 0);
    tick(1);
    wr_data = 36'hA_BCDE_012C; ld_strobe = 1; tick(1); ld_strobe = 0;
    chk("R4", "y second strobe", int'(y_ofs), 300);
    chk("R2", "x kept", int'(x_ofs), 5);
    cur_req = "R5";
    wr_data = 36'h7FF; ld_strobe = 1; tick(2); ld_strobe = 0;
    chk("R5", "x after extra strobes", int'(x_ofs), 5);
    chk("R5", "y after extra strobes", int'(y_ofs), 300);
    cur_req = "R8";
    fsel = 3'b000;
    occ = 5;    tick(1); chk("R8", "ae_n occ=5", int'(ae_n), 0);
    occ = 6;    tick(1); chk("R8", "ae_n occ=6", int'(ae_n), 1);
    cur_req = "R9";
    occ = 1748; tick(1); chk("R9", "af_n free=300", int'(af_n), 0);
    occ = 1747; tick(1); chk("R9", "af_n free=301", int'(af_n), 1);

    // serial
    cur_req = "R6";
    rst = 1; fsel = 3'b000; tick(2); rst = 0; tick(1);
    shift_word(11'h5A3, 3);
    chk("R6", "x after serial", int'(x_ofs), 11'h5A3);
    chk("R6", "y before serial", int'(y_ofs), 0);
    cur_req = "R10";
    prst = 1; fsel = 3'b011; tick(3); prst = 0; fsel = 3'b000; tick(1);
    chk("R10", "x kept over prst", int'(x_ofs), 11'h5A3);
    chk("R10", "y no shift in prst", int'(y_ofs), 0);
    cur_req = "R6";
    shift_word(11'h2C7, 4);
    chk("R6", "y after serial", int'(y_ofs), 11'h2C7);
    cur_req = "R7";
    fsel = 3'b011; tick(5); fsel = 3'b000;
    chk("R7", "x after extra bits", int'(x_ofs), 11'h5A3);
    chk("R7", "y after extra bits", int'(y_ofs), 11'h2C7);
    cur_req = "R5";
    wr_data = 36'h1; ld_strobe = 1; tick(2); ld_strobe = 0;
    chk("R5", "strobe ignored in serial", int'(x_ofs), 11'h5A3);
    occ = 11'h5A3; tick(1); chk("R8", "ae_n occ=X serial", int'(ae_n), 0);
    tick(2);

    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

  initial begin
    #100000;
    if (!done) begin
      done = 1;
      mismatched++;
      $display("FAIL watchdog expired act=running exp=finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  end

endmodule